// File: doc/BRIEF.md
# Barrel Multithreaded Stream Scheduler

This block chooses, once per clock, which hardware stream of a barrel-style multithreaded core issues its next instruction. Interleaving a different stream each cycle lets a long pipeline and slow memory stay busy without forwarding or stall logic. The scheduler keeps two facts per stream. One is whether an earlier instruction of that stream is still inside the deep pipeline. The other is how many memory references the stream has waiting for a reply.

The core tells the scheduler when an instruction leaves the pipeline. A flag on that notice says whether the instruction launched a memory reference. The memory system returns a notice when a reference completes. Software-controlled enable bits say which streams exist. The scheduler registers its choice and presents it as a stream number with a valid bit. When no stream can go, valid is low for that cycle. The default size is 128 streams with at most 8 references outstanding per stream. A pipeline of 21 stages therefore never holds more than 21 streams at once.

Top module: `barrel_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, issue_valid is low. Reset leaves every stream with no instruction in flight and zero references outstanding, and the first grant after reset goes to the lowest enabled stream, starting from stream 0.
- R2: A stream whose stream_en bit is low in the cycle before the output edge is never granted.
- R3: A granted stream is not granted again until an exit notice names it. A notice sampled on one edge lets the stream be granted on the next edge.
- R4: An exit notice with exit_mem high adds one to that stream's outstanding count. A stream whose count equals MAX_REFS (8) is not granted.
- R5: A reply notice takes one from that stream's count. A reply to a stream whose count is zero has no effect.
- R6: Grants rotate. The search starts at the stream after the last one granted and wraps from the highest stream number to 0.
- R7: When no stream is enabled, idle and under its reference limit, issue_valid is low for that cycle.
- R8: Two grants on consecutive cycles never name the same stream.
- R9: An exit notice for a stream with no instruction in flight is ignored, and so is its memory flag.
- R10: A memory-flagged exit and a reply for the same stream in the same cycle leave that stream's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stream_en | input | NUM_STREAMS | One enable bit per stream |
| exit_valid | input | 1 | An instruction left the pipeline this cycle |
| exit_id | input | log2(NUM_STREAMS) | Stream of the leaving instruction |
| exit_mem | input | 1 | The leaving instruction launched a memory reference |
| reply_valid | input | 1 | A memory reference completed this cycle |
| reply_id | input | log2(NUM_STREAMS) | Stream owning the completed reference |
| issue_valid | output | 1 | A stream is granted this cycle (registered) |
| issue_id | output | log2(NUM_STREAMS) | Granted stream number (registered) |

## Verification
The bound checker watches every cycle for these rules: a grant only goes to a stream that was enabled and idle, a grant sets that stream busy, a grant never goes to a stream at its reference cap, consecutive grants differ, and valid is high exactly when some stream was ready. The exact order of rotation, the counting up and down of references, a reply to a zero count being dropped, an exit for an idle stream being dropped, and a simultaneous exit and reply cancelling all show only over long runs. The bench runs those scenarios against a model that feeds exits back after a 21-cycle pipeline and compares every granted stream and every bubble.

// File: rtl/barrel_sched_pkg.sv
package barrel_sched_pkg;

  // Width needed to hold values 0..n-1, never less than one bit.
  function automatic int idw(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/stream_slot.sv
module stream_slot #(
  parameter int MAX_REFS = 8,
  parameter int RW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          take,
  input  logic          exit_hit,
  input  logic          exit_mem,
  input  logic          reply_hit,
  output logic          ready,
  output logic          busy,
  output logic [RW-1:0] refs
);

  logic exit_live;
  logic up;
  logic dn;

  // An exit only counts when this stream really has something in flight.
  assign exit_live = exit_hit & busy;
  assign up        = exit_live & exit_mem;
  assign dn        = reply_hit & (refs != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      refs <= '0;
    end else begin
      if (take)
        busy <= 1'b1;
      else if (exit_live)
        busy <= 1'b0;
      case ({up, dn})
        2'b10:   refs <= refs + RW'(1);
        2'b01:   refs <= refs - RW'(1);
        default: refs <= refs;
      endcase
    end
  end

  assign ready = en & ~busy & (refs < RW'(MAX_REFS));

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 128,
  parameter int IW = 7
) (
  input  logic [N-1:0]  ready,
  input  logic [IW-1:0] last,
  output logic          grant_v,
  output logic [IW-1:0] grant_id
);

  logic [IW:0] slot;

  // Walk from the farthest candidate to the nearest one so that the
  // stream right after "last" ends up with the final say.
  always_comb begin
    grant_v  = 1'b0;
    grant_id = '0;
    slot     = '0;
    for (int k = N; k >= 1; k--) begin
      slot = {1'b0, last} + (IW+1)'(k);
      if (slot >= (IW+1)'(N))
        slot = slot - (IW+1)'(N);
      if (ready[slot[IW-1:0]]) begin
        grant_v  = 1'b1;
        grant_id = slot[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/barrel_sched.sv
module barrel_sched #(
  parameter int NUM_STREAMS = 128,
  parameter int MAX_REFS    = 8,
  localparam int IW = barrel_sched_pkg::idw(NUM_STREAMS),
  localparam int RW = barrel_sched_pkg::idw(MAX_REFS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_STREAMS-1:0] stream_en,
  input  logic                   exit_valid,
  input  logic [IW-1:0]          exit_id,
  input  logic                   exit_mem,
  input  logic                   reply_valid,
  input  logic [IW-1:0]          reply_id,
  output logic                   issue_valid,
  output logic [IW-1:0]          issue_id
);

  logic [NUM_STREAMS-1:0]    ready_vec;
  logic [NUM_STREAMS-1:0]    busy_vec;
  logic [NUM_STREAMS*RW-1:0] refs_flat;
  logic                      grant_v;
  logic [IW-1:0]             grant_id;
  logic [IW-1:0]             last_q;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_slot
    stream_slot #(
      .MAX_REFS (MAX_REFS),
      .RW       (RW)
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .en        (stream_en[i]),
      .take      (grant_v && (grant_id == IW'(i))),
      .exit_hit  (exit_valid && (exit_id == IW'(i))),
      .exit_mem  (exit_mem),
      .reply_hit (reply_valid && (reply_id == IW'(i))),
      .ready     (ready_vec[i]),
      .busy      (busy_vec[i]),
      .refs      (refs_flat[i*RW +: RW])
    );
  end

  rr_pick #(
    .N  (NUM_STREAMS),
    .IW (IW)
  ) u_pick (
    .ready    (ready_vec),
    .last     (last_q),
    .grant_v  (grant_v),
    .grant_id (grant_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_id    <= '0;
      last_q      <= IW'(NUM_STREAMS - 1);
    end else begin
      issue_valid <= grant_v;
      if (grant_v) begin
        issue_id <= grant_id;
        last_q   <= grant_id;
      end
    end
  end

endmodule

// File: rtl/barrel_sched_chk.sv
module barrel_sched_chk #(
  parameter int NUM_STREAMS = 128,
  parameter int MAX_REFS    = 8,
  localparam int IW = barrel_sched_pkg::idw(NUM_STREAMS),
  localparam int RW = barrel_sched_pkg::idw(MAX_REFS + 1)
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_STREAMS-1:0]    stream_en,
  input logic                      issue_valid,
  input logic [IW-1:0]             issue_id,
  input logic [NUM_STREAMS-1:0]    ready_vec,
  input logic [NUM_STREAMS-1:0]    busy_vec,
  input logic [NUM_STREAMS*RW-1:0] refs_flat
);

  logic [NUM_STREAMS-1:0]    en_d;
  logic [NUM_STREAMS-1:0]    busy_d;
  logic [NUM_STREAMS-1:0]    ready_d;
  logic [NUM_STREAMS*RW-1:0] refs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d    <= '0;
      busy_d  <= '0;
      ready_d <= '0;
      refs_d  <= '0;
    end else begin
      en_d    <= stream_en;
      busy_d  <= busy_vec;
      ready_d <= ready_vec;
      refs_d  <= refs_flat;
    end
  end

  // R2
  assert_enabled_only_R2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> en_d[issue_id]);

  // R3: granted stream was idle one cycle earlier, and is busy now
  assert_idle_before_grant_R3: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> !busy_d[issue_id]);

  assert_marked_busy_R3: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> busy_vec[issue_id]);

  // R4
  assert_under_cap_R4: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (refs_d[issue_id*RW +: RW] < RW'(MAX_REFS)));

  // R7
  assert_bubble_R7: assert property (@(posedge clk) disable iff (rst)
    issue_valid == (|ready_d));

  // R8
  assert_switch_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid)) |-> (issue_id != $past(issue_id)));

endmodule

bind barrel_sched barrel_sched_chk #(
  .NUM_STREAMS (NUM_STREAMS),
  .MAX_REFS    (MAX_REFS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stream_en   (stream_en),
  .issue_valid (issue_valid),
  .issue_id    (issue_id),
  .ready_vec   (ready_vec),
  .busy_vec    (busy_vec),
  .refs_flat   (refs_flat)
);

// File: tb/barrel_sched_bench.sv
`timescale 1ns/1ps
module barrel_sched_bench;

  localparam int N   = 8;
  localparam int MAX = 8;
  localparam int LAT = 21;
  localparam int IW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  stream_en = '0;
  logic          exit_valid = 1'b0;
  logic [IW-1:0] exit_id = '0;
  logic          exit_mem = 1'b0;
  logic          reply_valid = 1'b0;
  logic [IW-1:0] reply_id = '0;
  logic          issue_valid;
  logic [IW-1:0] issue_id;

  always #5 clk = ~clk;

  barrel_sched #(.NUM_STREAMS(N), .MAX_REFS(MAX)) u_barrel_sched (
    .clk(clk), .rst(rst), .stream_en(stream_en),
    .exit_valid(exit_valid), .exit_id(exit_id), .exit_mem(exit_mem),
    .reply_valid(reply_valid), .reply_id(reply_id),
    .issue_valid(issue_valid), .issue_id(issue_id));

  typedef struct { bit v; int id; string tag; } exp_t;
  exp_t q[$];

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  // Behavioural model built from the requirements.
  bit  m_busy [N];
  int  m_refs [N];
  int  m_ptr;
  int  pipe   [LAT];
  bit  memset [N];

  task automatic check(input bit ok, input string tag, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected grant.
  task automatic step(input logic [N-1:0] en, input int rep, input bit rep_on_exit,
                      input int force_exit, input string tag);
    int  ex;
    int  r;
    int  pk;
    bit  exm;
    bit  inc;
    bit  dec;
    exp_t e;
    ex = pipe[0];
    if (ex < 0 && force_exit >= 0) ex = force_exit;
    exm = (ex >= 0) && memset[ex];
    r = rep_on_exit ? ex : rep;
    stream_en   = en;
    exit_valid  = (ex >= 0);
    exit_id     = (ex >= 0) ? IW'(ex) : '0;
    exit_mem    = exm;
    reply_valid = (r >= 0);
    reply_id    = (r >= 0) ? IW'(r) : '0;
    pk = -1;
    for (int k = N; k >= 1; k--) begin
      int idx;
      idx = (m_ptr + k) % N;
      if (en[idx] && !m_busy[idx] && m_refs[idx] < MAX) pk = idx;
    end
    e.v = (pk >= 0); e.id = pk; e.tag = tag;
    q.push_back(e);
    inc = 0;
    if (ex >= 0 && m_busy[ex]) begin
      m_busy[ex] = 0;
      inc = exm;
    end
    dec = (r >= 0) && (m_refs[r] > 0);
    if (inc) m_refs[ex] = m_refs[ex] + 1;
    if (dec) m_refs[r]  = m_refs[r] - 1;
    if (pk >= 0) begin
      m_busy[pk] = 1;
      m_ptr = pk;
    end
    for (int i = 0; i < LAT - 1; i++) pipe[i] = pipe[i+1];
    pipe[LAT-1] = pk;
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic [N-1:0] en, input int rep,
                     input bit roe, input int fx, input string tag);
    for (int i = 0; i < n; i++) step(en, (i == 0) ? rep : -1, roe, fx, tag);
  endtask

  // Monitor: compares each registered output against the scoreboard.
  always @(posedge clk) begin
    #3;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.v)
        check(issue_valid === 1'b1 && int'(issue_id) == e.id, e.tag,
              $sformatf("got v=%0d id=%0d expected v=1 id=%0d", issue_valid, issue_id, e.id));
      else
        check(issue_valid === 1'b0, e.tag,
              $sformatf("got v=%0d id=%0d expected v=0 (bubble)", issue_valid, issue_id));
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_refs[i] = 0; memset[i] = 0; end
    for (int i = 0; i < LAT; i++) pipe[i] = -1;
    m_ptr = N - 1;
    stream_en = '1;
    repeat (4) @(negedge clk);
    // R1: output low while in reset
    check(issue_valid === 1'b0, "R1", $sformatf("got v=%0d expected v=0 in reset", issue_valid));
    rst = 1'b0;
    // R1, R6, R7, R8, R3: rotation from stream 0, bubbles until exits return
    run(60, '1, -1, 0, -1, "R1/R6");
    // R2: half the streams off
    run(60, 8'b1010_0101, -1, 0, -1, "R2");
    // R4: stream 3 launches a reference on every exit until capped
    memset[3] = 1;
    run(260, '1, -1, 0, -1, "R4");
    // R5: reply to an idle-count stream is dropped, then stream 3 is released
    memset[3] = 0;
    step('1, 5, 0, -1, "R5");
    run(60, '1, 3, 0, -1, "R5");
    // R10: every exit answered by a reply for the same stream
    memset[3] = 1;
    run(200, '1, -1, 1, -1, "R10");
    memset[3] = 0;
    // R9: exits for idle, disabled stream 6 carrying the memory flag
    run(30, 8'b1011_1111, -1, 0, -1, "R9");
    memset[6] = 1;
    run(60, 8'b1011_1111, -1, 0, 6, "R9");
    memset[6] = 0;
    run(60, '1, -1, 0, -1, "R9");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule